// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Decoder

This block is the device-side control of a dynamic memory whose row and column addresses share one set of pins. It samples the row strobe, two byte-lane column strobes, the write strobe and the output-enable strobe on every clock, all active low. From the sequence of edges it recovers the row and column addresses, the kind of cycle under way, the byte lanes to write and the byte lanes whose data outputs are enabled. A small inferred cell array holds the data.

The column latch follows the address pins while both column strobes are high and freezes on the first column strobe to fall. A column strobe that is already low when the row strobe falls marks a refresh cycle. Such a cycle takes its row from an internal counter instead of the address pins, and the counter then steps. A finished cycle is reported with a one-clock pulse and a kind code.

Top module: `dram_strobe_dec`

## Requirements
- R1: On the first sample with `ras_n_i` low after a high sample, `row_o` takes `addr_i` (row-addressed cycles) one clock later and holds it until the row strobe rises.
- R2: While `ras_n_i` is low and both column strobes were high in the previous sample, the column used for the array is `addr_i`. The column is captured at the first column strobe fall and ignores later address changes.
- R3: A second column strobe falling while the other is still low does not recapture the column. The column is captured again only at a column strobe fall that follows a sample with both strobes high.
- R4: If either column strobe is low in the sample where the row strobe is first seen low, the cycle is a refresh. `row_o` takes the internal counter value and ignores `addr_i`, the counter steps by one, and no lane is driven.
- R5: With a column strobe held low across several row strobe cycles, each row strobe fall refreshes the next counter row.
- R6: The refresh counter `ref_row_o` resets to 0, wraps from 1023 to 0 and does not change during access or row-only cycles.
- R7: A row strobe cycle with no column strobe fall is a row-only refresh of `addr_i`. Its outputs stay undriven even with `oe_n_i` low.
- R8: `dq_oe_o[0]` (lower lane, `dq_o[7:0]`) and `dq_oe_o[1]` (upper lane, `dq_o[15:8]`) are high only while `ras_n_i`, that lane's column strobe and `oe_n_i` are all low in an access cycle. `dq_o` then carries the addressed word.
- R9: If `we_n_i` is low at the first column strobe fall, no lane is driven until both column strobes are high or the row strobe rises, whatever `oe_n_i` and `we_n_i` do in between.
- R10: `wr_be_o[l]` is high, and lane l of `dq_i` is written at the next clock, when lane l's column strobe falls with `we_n_i` low (early write) or when `we_n_i` falls with that column strobe already low (delayed write).
- R11: One clock after `ras_n_i` is first sampled high, `cyc_done_o` pulses for one clock. `cyc_kind_o` is then 1 for access, 2 for row-only refresh or 3 for counter refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| lcas_n_i | input | 1 | Lower-lane column strobe, active low |
| ucas_n_i | input | 1 | Upper-lane column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| dq_i | input | 16 | Write data |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 2 | Per-lane output drive enable |
| wr_be_o | output | 2 | Per-lane write strobe |
| row_o | output | 10 | Row latched for the current cycle |
| ref_row_o | output | 10 | Internal refresh counter |
| cyc_done_o | output | 1 | One-clock pulse at cycle end |
| cyc_kind_o | output | 2 | Kind of the ended cycle |

## Verification
The column freeze and the write capture fall in the same sample at an early write. Both lanes' strobes fall with the write strobe already low, so the column is taken from the pins in that sample, the word is written at that column, and the lanes stay undriven with output enable low. A readback of the same word in a later cycle shows that capture and write used one address. A delayed write to a second column, and a page where the second lane falls late, show that the column stays frozen until both strobes rise.

// File: rtl/dram_sd_pkg.sv
package dram_sd_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ACCESS = 2'd1,
    KIND_ROR    = 2'd2,
    KIND_CBR    = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/dram_sd_edge.sv
module dram_sd_edge #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '1;
    else         q_o <= sig_i;
  end
  assign fall_o = q_o & ~sig_i;
endmodule

// File: rtl/dram_sd_refctr.sv
module dram_sd_refctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_sd_array.sv
module dram_sd_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [LANES*BYTE_W-1:0] wdata_i,
  output logic [LANES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_be_i[l]) mem[addr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
    end
    assign rdata_o[l*BYTE_W +: BYTE_W] = mem[addr_i];
  end
endmodule

// File: rtl/dram_strobe_dec.sv
module dram_strobe_dec
  import dram_sd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 8,
  parameter int ARR_ROW_W = 3,
  parameter int ARR_COL_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_n_i,
  input  logic                  lcas_n_i,
  input  logic                  ucas_n_i,
  input  logic                  we_n_i,
  input  logic                  oe_n_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*BYTE_W-1:0]   dq_i,
  output logic [2*BYTE_W-1:0]   dq_o,
  output logic [1:0]            dq_oe_o,
  output logic [1:0]            wr_be_o,
  output logic [ADDR_W-1:0]     row_o,
  output logic [ADDR_W-1:0]     ref_row_o,
  output logic                  cyc_done_o,
  output logic [1:0]            cyc_kind_o
);
  localparam int LANES  = 2;
  localparam int ARR_AW = ARR_ROW_W + ARR_COL_W;
  localparam int STB_W  = LANES + 2;
  localparam int RAS_B  = LANES;
  localparam int WE_B   = LANES + 1;

  logic [LANES-1:0] cas_lo, cas_lo_q;
  logic [STB_W-1:0] stb_q, stb_fall;
  logic ras_fall, ras_rise, we_fall, ras_lo, any_cas_lo, cas_idle_q;
  logic cbr_start, row_start, col_track, first_fall, ew_now;
  logic row_act_q, cbr_q, cas_seen_q, ew_q, done_q;
  cyc_kind_e kind_q;
  logic [ADDR_W-1:0]    row_q, ref_cnt;
  logic [ARR_COL_W-1:0] col_q, col_eff;
  logic [LANES-1:0]     lane_wr, lane_oe;

  assign cas_lo = ~{ucas_n_i, lcas_n_i};

  dram_sd_edge #(.W(STB_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({we_n_i, ras_n_i, ucas_n_i, lcas_n_i}),
    .q_o    (stb_q),
    .fall_o (stb_fall)
  );

  assign cas_lo_q   = ~stb_q[LANES-1:0];
  assign ras_fall   = stb_fall[RAS_B];
  assign ras_rise   = ~stb_q[RAS_B] & ras_n_i;
  assign we_fall    = stb_fall[WE_B];
  assign ras_lo     = ~ras_n_i;
  assign any_cas_lo = |cas_lo;
  assign cas_idle_q = ~|cas_lo_q;

  // strobe order at the row edge picks the refresh source
  assign cbr_start  = ras_fall & any_cas_lo;
  assign row_start  = ras_fall & ~any_cas_lo;
  // column latch transparent until the first column strobe fall
  assign col_track  = row_act_q & ras_lo & cas_idle_q;
  assign first_fall = col_track & any_cas_lo;
  assign col_eff    = col_track ? addr_i[ARR_COL_W-1:0] : col_q;
  assign ew_now     = ew_q | (first_fall & ~we_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_act_q  <= 1'b0;
      cbr_q      <= 1'b0;
      cas_seen_q <= 1'b0;
      ew_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      done_q     <= 1'b0;
      kind_q     <= KIND_NONE;
    end else begin
      if (ras_rise) begin
        row_act_q <= 1'b0;
        cbr_q     <= 1'b0;
      end else begin
        if (row_start) row_act_q <= 1'b1;
        if (cbr_start) cbr_q     <= 1'b1;
      end
      if (ras_fall) row_q <= cbr_start ? ref_cnt : addr_i;
      if (row_start || col_track) col_q <= addr_i[ARR_COL_W-1:0];
      if (ras_fall)        cas_seen_q <= 1'b0;
      else if (first_fall) cas_seen_q <= 1'b1;
      if (ras_n_i || !any_cas_lo)      ew_q <= 1'b0;
      else if (first_fall && !we_n_i)  ew_q <= 1'b1;
      done_q <= ras_rise;
      if (ras_rise) kind_q <= cbr_q ? KIND_CBR : (cas_seen_q ? KIND_ACCESS : KIND_ROR);
    end
  end

  dram_sd_refctr #(.W(ADDR_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cbr_start),
    .cnt_o  (ref_cnt)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wr[l] = row_act_q & ras_lo & cas_lo[l] & ~we_n_i & (stb_fall[l] | we_fall);
    assign lane_oe[l] = row_act_q & ras_lo & cas_lo[l] & ~oe_n_i & ~ew_now;
  end

  dram_sd_array #(.AW(ARR_AW), .LANES(LANES), .BYTE_W(BYTE_W)) u_arr (
    .clk_i   (clk_i),
    .addr_i  ({row_q[ARR_ROW_W-1:0], col_eff}),
    .wr_be_i (lane_wr),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  assign wr_be_o    = lane_wr;
  assign dq_oe_o    = lane_oe;
  assign row_o      = row_q;
  assign ref_row_o  = ref_cnt;
  assign cyc_done_o = done_q;
  assign cyc_kind_o = kind_q;
endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_n_i,
  input logic              lcas_n_i,
  input logic              ucas_n_i,
  input logic              we_n_i,
  input logic              oe_n_i,
  input logic [1:0]        dq_oe_o,
  input logic [1:0]        wr_be_o,
  input logic [ADDR_W-1:0] row_o,
  input logic [ADDR_W-1:0] ref_row_o,
  input logic              cyc_done_o
);
  p_row_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!ras_n_i) && $past(!ras_n_i, 2)) |-> $stable(row_o));

  p_ref_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_row_o != $past(ref_row_o)) |-> $past(!ras_n_i && !(lcas_n_i && ucas_n_i)));

  p_ref_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_row_o != $past(ref_row_o)) |-> (ref_row_o == ADDR_W'($past(ref_row_o) + 1'b1)));

  p_lo_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o[0] |-> (!ras_n_i && !lcas_n_i && !oe_n_i));

  p_hi_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o[1] |-> (!ras_n_i && !ucas_n_i && !oe_n_i));

  p_wr_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_be_o) |-> (!we_n_i && !ras_n_i));

  p_done_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_done_o |-> ($past(ras_n_i) && $past(!ras_n_i, 2)));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_done_o |=> !cyc_done_o);
endmodule

bind dram_strobe_dec dram_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_n_i    (ras_n_i),
  .lcas_n_i   (lcas_n_i),
  .ucas_n_i   (ucas_n_i),
  .we_n_i     (we_n_i),
  .oe_n_i     (oe_n_i),
  .dq_oe_o    (dq_oe_o),
  .wr_be_o    (wr_be_o),
  .row_o      (row_o),
  .ref_row_o  (ref_row_o),
  .cyc_done_o (cyc_done_o)
);

// File: tb/dram_strobe_dec_tb_top.sv
module dram_strobe_dec_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_n_i = 1'b1, lcas_n_i = 1'b1, ucas_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
  logic [9:0]  addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o, wr_be_o, cyc_kind_o;
  logic [9:0]  row_o, ref_row_o;
  logic        cyc_done_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct {
    string       req;
    logic [15:0] d;
    logic [15:0] m;
    logic [1:0]  oe;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  always #5 clk_i = ~clk_i;

  dram_strobe_dec dut_i (
    .clk_i, .rst_ni, .ras_n_i, .lcas_n_i, .ucas_n_i, .we_n_i, .oe_n_i,
    .addr_i, .dq_i, .dq_o, .dq_oe_o, .wr_be_o, .row_o, .ref_row_o,
    .cyc_done_o, .cyc_kind_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // driver side: push expected output and let the monitor compare
  task automatic exp_rd(string req, logic [15:0] d, logic [15:0] m, logic [1:0] oe);
    item_t it;
    #2;
    it.req = req; it.d = d; it.m = m; it.oe = oe;
    sb_q.push_back(it);
    -> smp_ev;
    #3;
  endtask

  initial begin
    forever begin
      @(smp_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk({it.req, " oe"}, {30'd0, dq_oe_o}, {30'd0, it.oe});
        if (it.m != 16'h0)
          chk({it.req, " data"}, {16'd0, dq_o & it.m}, {16'd0, it.d & it.m});
      end
    end
  end

  task automatic end_cyc();
    tick(); ras_n_i = 1'b1; lcas_n_i = 1'b1; ucas_n_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    chk("R11 reset done", {31'd0, cyc_done_o}, 32'd0);
    chk("R8 reset oe", {30'd0, dq_oe_o}, 32'd0);
    chk("R10 reset wr", {30'd0, wr_be_o}, 32'd0);
    chk("R6 reset ref", {22'd0, ref_row_o}, 32'd0);

    // early write, both lanes, row 5 col 3
    tick(); ras_n_i = 1'b0; addr_i = 10'd5;
    tick(); #1 chk("R1 row latch", {22'd0, row_o}, 32'd5);
    addr_i = 10'd3; we_n_i = 1'b0; dq_i = 16'hA55A; oe_n_i = 1'b0;
    tick(); lcas_n_i = 1'b0; ucas_n_i = 1'b0;
    #1 chk("R10 early write strobes", {30'd0, wr_be_o}, 32'd3);
    exp_rd("R9 early write no drive", 16'h0, 16'h0, 2'b00);
    tick(); we_n_i = 1'b1;
    #1 chk("R10 no strobe after", {30'd0, wr_be_o}, 32'd0);
    exp_rd("R9 held after W rise", 16'h0, 16'h0, 2'b00);
    tick(); ras_n_i = 1'b1; lcas_n_i = 1'b1; ucas_n_i = 1'b1; addr_i = 10'd9; oe_n_i = 1'b1;
    tick(); #1 chk("R11 done pulse", {31'd0, cyc_done_o}, 32'd1);
    chk("R11 kind access", {30'd0, cyc_kind_o}, 32'd1);
    chk("R6 no step on access", {22'd0, ref_row_o}, 32'd0);
    tick(); #1 chk("R11 pulse one clock", {31'd0, cyc_done_o}, 32'd0);

    // read row 5 col 3, then address change while frozen
    tick(); ras_n_i = 1'b0; addr_i = 10'd5; oe_n_i = 1'b0;
    tick(); addr_i = 10'd3; lcas_n_i = 1'b0; ucas_n_i = 1'b0;
    exp_rd("R8 read both lanes", 16'hA55A, 16'hFFFF, 2'b11);
    tick(); addr_i = 10'd6;
    exp_rd("R2 column frozen", 16'hA55A, 16'hFFFF, 2'b11);
    tick(); oe_n_i = 1'b1;
    exp_rd("R8 OE high", 16'h0, 16'h0, 2'b00);
    tick(); oe_n_i = 1'b0; lcas_n_i = 1'b1;
    exp_rd("R8 upper lane only", 16'hA500, 16'hFF00, 2'b10);
    end_cyc();

    // delayed write row 5 col 6
    tick(); ras_n_i = 1'b0; addr_i = 10'd5;
    tick(); addr_i = 10'd6; lcas_n_i = 1'b0; ucas_n_i = 1'b0;
    tick(); we_n_i = 1'b0; dq_i = 16'h3C96;
    #1 chk("R10 delayed write strobes", {30'd0, wr_be_o}, 32'd3);
    tick(); we_n_i = 1'b1;
    #1 chk("R10 delayed write ends", {30'd0, wr_be_o}, 32'd0);
    end_cyc();

    // upper-lane early write row 5 col 3
    tick(); ras_n_i = 1'b0; addr_i = 10'd5;
    tick(); addr_i = 10'd3; we_n_i = 1'b0; dq_i = 16'h1299;
    tick(); ucas_n_i = 1'b0;
    #1 chk("R10 upper lane strobe", {30'd0, wr_be_o}, 32'd2);
    end_cyc();

    // staggered strobes: no relatch, then reopen
    tick(); ras_n_i = 1'b0; addr_i = 10'd5; oe_n_i = 1'b0;
    tick(); addr_i = 10'd3; lcas_n_i = 1'b0;
    exp_rd("R8 lower lane only", 16'h005A, 16'h00FF, 2'b01);
    tick(); addr_i = 10'd6; ucas_n_i = 1'b0;
    exp_rd("R3 no relatch", 16'h125A, 16'hFFFF, 2'b11);
    tick(); lcas_n_i = 1'b1; ucas_n_i = 1'b1;
    exp_rd("R8 strobes high", 16'h0, 16'h0, 2'b00);
    tick(); lcas_n_i = 1'b0; ucas_n_i = 1'b0;
    exp_rd("R3 reopened column", 16'h3C96, 16'hFFFF, 2'b11);
    end_cyc();

    // row-only refresh
    tick(); ras_n_i = 1'b0; addr_i = 10'd7; oe_n_i = 1'b0;
    tick();
    exp_rd("R7 row-only no drive", 16'h0, 16'h0, 2'b00);
    chk("R7 row-only row", {22'd0, row_o}, 32'd7);
    tick(); ras_n_i = 1'b1; oe_n_i = 1'b1;
    tick(); #1 chk("R7 kind row-only", {30'd0, cyc_kind_o}, 32'd2);
    chk("R11 done row-only", {31'd0, cyc_done_o}, 32'd1);
    chk("R6 no step on row-only", {22'd0, ref_row_o}, 32'd0);

    // counter refresh
    tick(); lcas_n_i = 1'b0; addr_i = 10'd4; oe_n_i = 1'b0;
    tick(); ras_n_i = 1'b0;
    tick(); #1 chk("R4 internal row", {22'd0, row_o}, 32'd0);
    chk("R4 counter stepped", {22'd0, ref_row_o}, 32'd1);
    exp_rd("R4 no drive", 16'h0, 16'h0, 2'b00);
    tick(); ras_n_i = 1'b1;
    tick(); #1 chk("R11 kind refresh", {30'd0, cyc_kind_o}, 32'd3);
    tick(); ras_n_i = 1'b0;
    tick(); #1 chk("R5 next row", {22'd0, row_o}, 32'd1);
    chk("R5 counter", {22'd0, ref_row_o}, 32'd2);
    tick(); ras_n_i = 1'b1;
    for (int i = 0; i < 1021; i++) begin
      tick(); ras_n_i = 1'b0;
      tick(); ras_n_i = 1'b1;
    end
    tick(); #1 chk("R6 counter top", {22'd0, ref_row_o}, 32'd1023);
    tick(); ras_n_i = 1'b0;
    tick(); #1 chk("R6 counter wraps", {22'd0, ref_row_o}, 32'd0);
    chk("R5 last row used", {22'd0, row_o}, 32'd1023);
    end_cyc();

    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule